// File: doc/BRIEF.md
# Erase-Block Protection State Manager

This block holds a protection state for every erase block of a flash array and decides whether the write state machine may program or erase a given block. Each block is in one of three states: open (writable), held (write-protected but releasable), or frozen (write-protected until reset). The state changes only through a two-cycle command: a setup code opens the sequence, and the code that follows names the action. The block address of the second cycle selects the target.

A program or erase request that targets a protected block is refused and raises error flags. A second cycle that is not one of the three protection actions is a sequence error. A query port returns the state of any block as a two-bit code, and a vector gives one write-allowed bit per block to the write state machine. The error flags stay set until reset.

Top module: `lock_mgr`

## Requirements
- R1: A command of code 0x60 arms the sequencer. The next valid command ends the sequence, and its block address selects the target (the address given with 0x60 is not used). While not armed, any code other than 0x60 is ignored.
- R2: A second-cycle code 0x01 sets the addressed block to held (query code 01), unless the block is frozen.
- R3: A second-cycle code 0xD0 sets a held or open block to open (query code 00).
- R4: A second-cycle code 0x2F sets the addressed block to frozen (query code 11) from any state.
- R5: An unlock (0xD0) aimed at a frozen block has no effect. A frozen block leaves that state only through reset.
- R6: Any other second-cycle code, including 0x60 itself, sets sr_prog_err and sr_erase_err and changes no block state.
- R7: A request (op_valid) aimed at a block that is not open sets sr_lock_err together with sr_erase_err (op_erase=1) or sr_prog_err (op_erase=0). A request aimed at an open block sets no flag. The request is judged on the block state before any command in the same cycle takes effect.
- R8: Reset sets every block to held, disarms the sequencer and clears all three flags. Once set, a flag stays set until reset.
- R9: qry_state returns the state of block qry_blk without a clock delay, coded 00 open, 01 held, 11 frozen. Bit i of blk_allowed is 1 exactly when block i is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command byte is present this cycle |
| cmd_code | input | 8 | Decoded command byte |
| cmd_blk | input | BLK_W | Block address of the command |
| op_valid | input | 1 | Program or erase request this cycle |
| op_erase | input | 1 | 1 for an erase request, 0 for a program request |
| op_blk | input | BLK_W | Block targeted by the request |
| qry_blk | input | BLK_W | Block whose state is queried |
| qry_state | output | 2 | State code of block qry_blk |
| blk_allowed | output | NUM_BLK | Per-block write-allowed flags |
| sr_lock_err | output | 1 | Sticky flag: a request hit a protected block |
| sr_prog_err | output | 1 | Sticky program / sequence error flag |
| sr_erase_err | output | 1 | Sticky erase / sequence error flag |

## Verification
A wrong block state appears on blk_allowed at the clock edge after the second command cycle, and also on qry_state as soon as that block is queried. A sequencer left armed or disarmed by mistake shows up one cycle later, either as a block change that should not happen or as a missing or extra sequence error. A wrong refusal decision shows on the flags one edge after the request. The bench keeps its own model of every block state and compares the full allowed vector, the queried code and all three flags after every clock. Any divergence is therefore reported in the cycle it first becomes visible.

// File: rtl/lkm_pkg.sv
package lkm_pkg;

  // protection state; the bit pattern is the query code
  typedef enum logic [1:0] {
    LK_OPEN   = 2'b00,
    LK_HELD   = 2'b01,
    LK_FROZEN = 2'b11
  } lk_state_e;

  // decoded second-cycle action
  typedef enum logic [2:0] {
    EV_NONE,
    EV_SET,
    EV_CLR,
    EV_FRZ,
    EV_BAD
  } lk_ev_e;

  localparam logic [7:0] CMD_ARM  = 8'h60;
  localparam logic [7:0] CMD_SET  = 8'h01;
  localparam logic [7:0] CMD_CLR  = 8'hD0;
  localparam logic [7:0] CMD_FRZ  = 8'h2F;

  // classify the byte that follows an arm
  function automatic lk_ev_e lk_decode(logic [7:0] code);
    case (code)
      CMD_SET: return EV_SET;
      CMD_CLR: return EV_CLR;
      CMD_FRZ: return EV_FRZ;
      default: return EV_BAD;
    endcase
  endfunction

  // state transition for one block under one action
  function automatic lk_state_e lk_next(lk_state_e cur, lk_ev_e ev);
    if (cur == LK_FROZEN) return LK_FROZEN;
    case (ev)
      EV_SET:  return LK_HELD;
      EV_CLR:  return LK_OPEN;
      EV_FRZ:  return LK_FROZEN;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/lkm_seq.sv
module lkm_seq
  import lkm_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic [BLK_W-1:0] cmd_blk,
  output lk_ev_e           ev,
  output logic [BLK_W-1:0] ev_blk,
  output logic             armed
);

  logic armed_q;
  logic arm_hit;
  logic finish_hit;

  assign arm_hit    = !armed_q && cmd_valid && (cmd_code == CMD_ARM);
  assign finish_hit = armed_q && cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b0;
    else if (finish_hit) armed_q <= 1'b0;
    else if (arm_hit)    armed_q <= 1'b1;
  end

  assign ev     = finish_hit ? lk_decode(cmd_code) : EV_NONE;
  assign ev_blk = cmd_blk;
  assign armed  = armed_q;

  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && cmd_valid && cmd_code == CMD_ARM) |=> armed); // R1
  AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cmd_valid) |=> !armed); // R1

endmodule

// File: rtl/lkm_cell.sv
module lkm_cell
  import lkm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  lk_ev_e    ev,
  output lk_state_e st
);

  lk_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= LK_HELD;
    else if (hit) st_q <= lk_next(st_q, ev);
  end

  assign st = st_q;

  AST_SET_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ev == EV_SET) |=> (st != LK_OPEN)); // R2
  AST_CLR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ev == EV_CLR && st != LK_FROZEN) |=> (st == LK_OPEN)); // R3
  AST_FRZ_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ev == EV_FRZ) |=> (st == LK_FROZEN)); // R4
  AST_FROZEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_FROZEN) |=> (st == LK_FROZEN)); // R5
  AST_BAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_BAD) |=> $stable(st)); // R6

endmodule

// File: rtl/lkm_status.sv
module lkm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_err,
  input  logic refuse,
  input  logic refuse_erase,
  output logic sr_lock_err,
  output logic sr_prog_err,
  output logic sr_erase_err
);

  logic lock_q, prog_q, erase_q;
  logic set_prog, set_erase;

  assign set_prog  = seq_err || (refuse && !refuse_erase);
  assign set_erase = seq_err || (refuse && refuse_erase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      lock_q  <= lock_q  | refuse;
      prog_q  <= prog_q  | set_prog;
      erase_q <= erase_q | set_erase;
    end
  end

  assign sr_lock_err  = lock_q;
  assign sr_prog_err  = prog_q;
  assign sr_erase_err = erase_q;

  AST_SEQ_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (sr_prog_err && sr_erase_err)); // R6
  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (sr_lock_err && ($past(refuse_erase) ? sr_erase_err : sr_prog_err))); // R7
  AST_LOCK_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sr_lock_err |=> sr_lock_err); // R8
  AST_SEQ_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_prog_err && sr_erase_err) |=> (sr_prog_err && sr_erase_err)); // R8

endmodule

// File: rtl/lock_mgr.sv
module lock_mgr
  import lkm_pkg::*;
#(
  parameter int NUM_BLK = 16,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_code,
  input  logic [BLK_W-1:0]   cmd_blk,
  input  logic               op_valid,
  input  logic               op_erase,
  input  logic [BLK_W-1:0]   op_blk,
  input  logic [BLK_W-1:0]   qry_blk,
  output logic [1:0]         qry_state,
  output logic [NUM_BLK-1:0] blk_allowed,
  output logic               sr_lock_err,
  output logic               sr_prog_err,
  output logic               sr_erase_err
);

  function automatic logic in_range(logic [BLK_W-1:0] a);
    return int'(a) < NUM_BLK;
  endfunction

  lk_ev_e           seq_ev;
  logic [BLK_W-1:0] seq_blk;
  logic             seq_armed;
  logic             seq_err;
  logic             op_refuse;
  lk_state_e        blk_st [NUM_BLK];

  lkm_seq #(.BLK_W(BLK_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_blk   (cmd_blk),
    .ev        (seq_ev),
    .ev_blk    (seq_blk),
    .armed     (seq_armed)
  );

  assign seq_err = (seq_ev == EV_BAD);

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic hit;
    assign hit = (seq_ev != EV_NONE) && (seq_blk == BLK_W'(i));
    lkm_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .ev    (seq_ev),
      .st    (blk_st[i])
    );
    assign blk_allowed[i] = (blk_st[i] == LK_OPEN);
  end

  assign qry_state = in_range(qry_blk) ? 2'(blk_st[qry_blk]) : 2'(LK_HELD);
  assign op_refuse = op_valid && !(in_range(op_blk) && blk_allowed[op_blk]);

  lkm_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .seq_err      (seq_err),
    .refuse       (op_refuse),
    .refuse_erase (op_erase),
    .sr_lock_err  (sr_lock_err),
    .sr_prog_err  (sr_prog_err),
    .sr_erase_err (sr_erase_err)
  );

  AST_QRY_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    qry_state != 2'b10); // R9
  AST_IDLE_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_armed && !(cmd_valid && cmd_code == CMD_ARM)) |=> $stable(blk_allowed)); // R1

endmodule

// File: tb/lock_mgr_tb.sv
module lock_mgr_tb;
  localparam int NB = 16;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [7:0]    cmd_code;
  logic [BW-1:0] cmd_blk;
  logic          op_valid;
  logic          op_erase;
  logic [BW-1:0] op_blk;
  logic [BW-1:0] qry_blk;
  logic [1:0]    qry_state;
  logic [NB-1:0] blk_allowed;
  logic          sr_lock_err, sr_prog_err, sr_erase_err;

  always #5 clk = ~clk;

  lock_mgr #(.NUM_BLK(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_blk(cmd_blk), .op_valid(op_valid), .op_erase(op_erase), .op_blk(op_blk),
    .qry_blk(qry_blk), .qry_state(qry_state), .blk_allowed(blk_allowed),
    .sr_lock_err(sr_lock_err), .sr_prog_err(sr_prog_err), .sr_erase_err(sr_erase_err)
  );

  // reference model: 0 open, 1 held, 3 frozen
  int    m_st [NB];
  bit    m_armed, m_lk, m_pg, m_er;
  int    n_cmp, n_bad;
  string cur_req;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int exp_vec = 0;
    for (int b = 0; b < NB; b++) if (m_st[b] == 0) exp_vec |= (1 << b);
    chk(cur_req, "blk_allowed", int'(blk_allowed), exp_vec);
    chk(cur_req, "qry_state", int'(qry_state), m_st[qry_blk]);
    chk(cur_req, "sr_lock_err", int'(sr_lock_err), int'(m_lk));
    chk(cur_req, "sr_prog_err", int'(sr_prog_err), int'(m_pg));
    chk(cur_req, "sr_erase_err", int'(sr_erase_err), int'(m_er));
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) m_st[b] = 1;
    m_armed = 0; m_lk = 0; m_pg = 0; m_er = 0;
  endtask

  task automatic model_step();
    if (op_valid && m_st[op_blk] != 0) begin
      m_lk = 1;
      if (op_erase) m_er = 1; else m_pg = 1;
    end
    if (cmd_valid) begin
      if (m_armed) begin
        m_armed = 0;
        if (cmd_code == 8'h01)      begin if (m_st[cmd_blk] != 3) m_st[cmd_blk] = 1; end
        else if (cmd_code == 8'hD0) begin if (m_st[cmd_blk] != 3) m_st[cmd_blk] = 0; end
        else if (cmd_code == 8'h2F) m_st[cmd_blk] = 3;
        else begin m_pg = 1; m_er = 1; end
      end else if (cmd_code == 8'h60) m_armed = 1;
    end
  endtask

  // called at a falling edge; ends at the next falling edge after comparing
  task automatic step(bit cv, logic [7:0] cc, int cb, bit ov, bit oe, int ob, int qb);
    cmd_valid = cv; cmd_code = cc; cmd_blk = BW'(cb);
    op_valid = ov; op_erase = oe; op_blk = BW'(ob); qry_blk = BW'(qb);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic cmd2(logic [7:0] code, int blk);
    step(1, 8'h60, (blk + 5) % NB, 0, 0, 0, blk);
    step(1, code, blk, 0, 0, 0, blk);
  endtask

  task automatic do_reset();
    cmd_valid = 0; op_valid = 0;
    rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    cmd_valid = 0; cmd_code = 0; cmd_blk = 0;
    op_valid = 0; op_erase = 0; op_blk = 0; qry_blk = 0;
    rst_n = 1'b0;
    @(negedge clk);
    cur_req = "R8"; do_reset();

    // R1: idle codes ignored
    cur_req = "R1";
    step(1, 8'hD0, 2, 0, 0, 0, 2);
    step(1, 8'h2F, 2, 0, 0, 0, 2);
    // R3: unlock block 3, address taken from second cycle
    cur_req = "R3"; cmd2(8'hD0, 3);
    chk("R3", "blk3 open", int'(qry_state), 0);
    chk("R1", "first-cycle block untouched", int'(blk_allowed[8]), 0);
    // R7: open target accepted, protected target refused
    cur_req = "R7";
    step(0, 0, 0, 1, 0, 3, 3);
    chk("R7", "no flag on open block", int'(sr_lock_err), 0);
    step(0, 0, 0, 1, 0, 5, 5);
    chk("R7", "lock flag after program refuse", int'(sr_lock_err), 1);
    chk("R7", "program flag", int'(sr_prog_err), 1);
    cur_req = "R8"; step(0, 0, 0, 0, 0, 0, 0);
    do_reset();
    cur_req = "R7"; step(0, 0, 0, 1, 1, 9, 9);
    chk("R7", "erase flag after refuse", int'(sr_erase_err), 1);
    chk("R7", "program flag clear", int'(sr_prog_err), 0);
    do_reset();
    // R2: relock
    cur_req = "R3"; cmd2(8'hD0, 4);
    cur_req = "R2"; cmd2(8'h01, 4);
    chk("R2", "blk4 held", int'(qry_state), 1);
    // R4/R5: freeze, then unlock and lock attempts
    cur_req = "R4"; cmd2(8'hD0, 7); cmd2(8'h2F, 7);
    chk("R4", "blk7 frozen", int'(qry_state), 3);
    cur_req = "R5"; cmd2(8'hD0, 7);
    chk("R5", "unlock on frozen ignored", int'(qry_state), 3);
    cmd2(8'h01, 7);
    chk("R5", "lock keeps frozen", int'(qry_state), 3);
    // R7: op and command in the same cycle use the old state
    cur_req = "R7";
    step(1, 8'h60, 0, 0, 0, 0, 0);
    step(1, 8'hD0, 0, 1, 0, 0, 0);
    chk("R7", "refused on pre-command state", int'(sr_lock_err), 1);
    // R6: bad second code
    cur_req = "R8"; do_reset();
    cur_req = "R6"; cmd2(8'h20, 2);
    chk("R6", "seq err prog flag", int'(sr_prog_err), 1);
    chk("R6", "seq err erase flag", int'(sr_erase_err), 1);
    chk("R6", "block unchanged", int'(qry_state), 1);
    cur_req = "R8"; do_reset();
    cur_req = "R6"; cmd2(8'h60, 2);
    chk("R6", "double arm is error", int'(sr_erase_err), 1);
    // R8: frozen block returns to held after reset
    cur_req = "R4"; cmd2(8'h2F, 11);
    cur_req = "R8"; do_reset();
    step(0, 0, 0, 0, 0, 0, 11);
    chk("R8", "frozen cleared by reset", int'(qry_state), 1);
    // R9: query sweep
    cur_req = "R9";
    cmd2(8'hD0, 1); cmd2(8'h2F, 2);
    for (int b = 0; b < NB; b++) step(0, 0, 0, 0, 0, 0, b);
    // mixed traffic
    cur_req = "R9";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] codes [8] = '{8'h60, 8'h01, 8'hD0, 8'h2F, 8'h60, 8'h60, 8'hD0, 8'h20};
      if (k % 90 == 89) do_reset();
      else step(($urandom % 4) != 0, codes[$urandom % 8], $urandom % NB,
                ($urandom % 6) == 0, $urandom % 2, $urandom % NB, $urandom % NB);
    end
    summary();
    $finish;
  end
endmodule